// File: doc/BRIEF.md
# DRAM Bank Size Decoder

This block keeps the three memory-configuration bytes that firmware programs for four DRAM banks: two bytes that pack a 4-bit setting per bank, and one byte whose low four bits switch banks on. From each bank's setting it decodes a programmed module size. It compares that size with a static descriptor of the module that is really fitted, which gives the size in KiB and whether the module is double-sided. It then adds the usable sizes and drives a system memory map. The map has a conventional region from 0 to 640 KiB, and a high region that starts at 1 MiB together with its length and its top address.

Firmware reaches the registers through a byte-wide write/read port with an address. A write to any of the three registers starts a recomputation in a small state machine. The machine has three states. `S_IDLE` holds the map. `S_SUM` latches each bank's effective size. `S_MAP` adds the sizes and updates the map. The named transitions are:

- start: `S_IDLE`→`S_SUM` on a register write.
- restart: `S_SUM`→`S_SUM` or `S_MAP`→`S_SUM` on a write during recomputation.
- advance: `S_SUM`→`S_MAP`.
- publish: `S_MAP`→`S_IDLE`.

While the machine is in `S_SUM` or `S_MAP`, the valid flag stays low.

Top module: `dram_bank_decoder`

## Requirements
- R1: Bank 0 takes its setting from bits [3:0] of the byte at address 0x58, and bank 1 from bits [7:4] of that byte. Bank 2 takes bits [3:0] of address 0x59, and bank 3 takes bits [7:4] of 0x59.
- R2: In a bank setting, bits [1:0] are the module type and bit 3 marks a double-sided module. The size code is {type, bit3}, and code n decodes to 2048·2^n KiB (2 MiB up to 256 MiB).
- R3: Bit i of the byte at address 0x5C enables bank i. A disabled bank contributes 0 KiB.
- R4: If a bank's setting selects double-sided but the fitted module is single-sided (`inst_dbl[i]`=0), the decoded size is the one for the next lower code.
- R5: A bank's effective size is the smaller of its fitted size and its decoded size. `total_kib` is the sum of the four effective sizes.
- R6: If the total is above 1024 KiB, `low_en` and `high_en` are both 1, `high_len_kib` = total − 1024 and `high_top_kib` = total.
- R7: If the total is exactly 1024 KiB, only `low_en` is 1. If the total is below 1024 KiB, both enables are 0. In both cases `high_len_kib` and `high_top_kib` are 0.
- R8: A write to 0x58, 0x59 or 0x5C starts a recomputation. A write to any other address changes no register and leaves `map_valid` high.
- R9: After a triggering write clocked in at edge k, `map_valid` is 0 after edges k and k+1. The new map and `map_valid`=1 appear after edge k+2. A further write during this window restarts the count, and the map outputs keep their old values until they are updated.
- R10: After reset all three registers read 0, `map_valid` is 1, and every map output is 0.
- R11: `rdata` returns the stored byte for 0x58, 0x59 and 0x5C, and returns 0 for any other address.
- R12: Four enabled 256 MiB banks give a total of 1048576 KiB with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| inst_kib | input | 76 | Fitted size per bank, 19 bits each, bank i at [19i+18:19i] |
| inst_dbl | input | 4 | Fitted module double-sided, one bit per bank |
| map_valid | output | 1 | Map outputs are current |
| low_en | output | 1 | 0–640 KiB region enabled |
| high_en | output | 1 | Region from 1 MiB enabled |
| high_len_kib | output | 21 | Length of the high region in KiB |
| high_top_kib | output | 21 | End address of the high region in KiB |
| total_kib | output | 21 | Sum of the effective bank sizes in KiB |

## Verification
`rdata` is combinational, so the bench checks it one nanosecond after it changes `addr`, well clear of any clock edge. All other outputs are registered. A reference model advances on every rising edge and holds a countdown that a triggering write reloads to two. The bench compares `map_valid` and the map outputs against this model at every falling edge. The directed checks add to this. They sample `map_valid` at the first and second falling edges after the write edge, where it must be low. They sample the new map at the third falling edge, where the map must show the expected hand-computed values.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;

    localparam int NBANK   = 4;
    localparam int NIB_W   = 4;
    localparam int MIN_KIB = 2048;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SUM  = 2'd1,
        S_MAP  = 2'd2
    } recalc_state_t;

endpackage

// File: rtl/dram_cfg_regs.sv
module dram_cfg_regs #(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  CFG0_ADDR = 8'h58,
    parameter logic [7:0]  CFG1_ADDR = 8'h59,
    parameter logic [7:0]  EN_ADDR   = 8'h5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [15:0]       cfg_word,
    output logic [3:0]        bank_en,
    output logic              recalc_req
);

    logic [7:0] cfg0_q, cfg1_q, en_q;
    logic       hit_cfg0, hit_cfg1, hit_en;

    always_comb begin
        hit_cfg0 = (addr == ADDR_W'(CFG0_ADDR));
        hit_cfg1 = (addr == ADDR_W'(CFG1_ADDR));
        hit_en   = (addr == ADDR_W'(EN_ADDR));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg0_q <= '0;
            cfg1_q <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            if (hit_cfg0) cfg0_q <= wdata;
            if (hit_cfg1) cfg1_q <= wdata;
            if (hit_en)   en_q   <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_cfg0)      rdata = cfg0_q;
        else if (hit_cfg1) rdata = cfg1_q;
        else if (hit_en)   rdata = en_q;
    end

    assign cfg_word   = {cfg1_q, cfg0_q};
    assign bank_en    = en_q[3:0];
    assign recalc_req = wr_en && (hit_cfg0 || hit_cfg1 || hit_en);

    assert_foreign_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !recalc_req) |=> ($stable(cfg_word) && $stable(bank_en)));

    assert_readback_others_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_cfg0 && !hit_cfg1 && !hit_en) |-> (rdata == 8'h00));

endmodule

// File: rtl/dram_bank_eval.sv
module dram_bank_eval #(
    parameter int INST_W  = 19,
    parameter int MIN_KIB = 2048
) (
    input  logic [3:0]        setting,
    input  logic              bank_on,
    input  logic [INST_W-1:0] inst_kib,
    input  logic              inst_dbl,
    output logic [INST_W-1:0] eff_kib
);

    logic [2:0]        code_raw;
    logic [2:0]        code_use;
    logic              mismatch;
    logic [INST_W-1:0] prog_kib;

    always_comb begin
        code_raw = {setting[1:0], setting[3]};
        mismatch = setting[3] && !inst_dbl;
        code_use = mismatch ? (code_raw - 3'd1) : code_raw;
        prog_kib = INST_W'(MIN_KIB) << code_use;
        if (!bank_on)
            eff_kib = '0;
        else if (inst_kib < prog_kib)
            eff_kib = inst_kib;
        else
            eff_kib = prog_kib;
    end

    always_comb begin
        if (bank_on)
            assert_eff_within_fitted_R5: assert (eff_kib <= inst_kib);
    end

endmodule

// File: rtl/dram_map_ctrl.sv
module dram_map_ctrl
    import dram_map_pkg::*;
#(
    parameter int INST_W  = 19,
    parameter int TOT_W   = 21,
    parameter int LOW_KIB = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    recalc_req,
    input  logic [NBANK*INST_W-1:0] eff_flat,
    output logic                    map_valid,
    output logic                    low_en,
    output logic                    high_en,
    output logic [TOT_W-1:0]        high_len_kib,
    output logic [TOT_W-1:0]        high_top_kib,
    output logic [TOT_W-1:0]        total_kib
);

    recalc_state_t state_q, state_d;
    logic [INST_W-1:0] eff_q [NBANK];
    logic [TOT_W-1:0]  sum_d;
    logic              publish;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = recalc_req ? S_SUM : S_IDLE;
            S_SUM:   state_d = recalc_req ? S_SUM : S_MAP;
            S_MAP:   state_d = recalc_req ? S_SUM : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        sum_d = '0;
        for (int b = 0; b < NBANK; b++)
            sum_d = sum_d + TOT_W'(eff_q[b]);
        publish = (state_q == S_MAP) && !recalc_req;
    end

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_latch
            always_ff @(posedge clk) begin
                if (!rst_n)
                    eff_q[g] <= '0;
                else if (state_q == S_SUM)
                    eff_q[g] <= eff_flat[g*INST_W +: INST_W];
            end
            always_comb begin
                if (rst_n)
                    assert_no_overflow_R12: assert (sum_d >= TOT_W'(eff_q[g]));
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_valid    <= 1'b1;
            low_en       <= 1'b0;
            high_en      <= 1'b0;
            high_len_kib <= '0;
            high_top_kib <= '0;
            total_kib    <= '0;
        end else if (recalc_req) begin
            map_valid <= 1'b0;
        end else if (publish) begin
            map_valid <= 1'b1;
            total_kib <= sum_d;
            if (sum_d > TOT_W'(LOW_KIB)) begin
                low_en       <= 1'b1;
                high_en      <= 1'b1;
                high_len_kib <= sum_d - TOT_W'(LOW_KIB);
                high_top_kib <= sum_d;
            end else begin
                low_en       <= (sum_d == TOT_W'(LOW_KIB));
                high_en      <= 1'b0;
                high_len_kib <= '0;
                high_top_kib <= '0;
            end
        end
    end

    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recalc_req |=> !map_valid);

    assert_valid_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MAP && !recalc_req) |=> map_valid);

    assert_map_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_MAP) |=> ($stable(total_kib) && $stable(high_en) && $stable(low_en)));

    assert_high_needs_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        high_en |-> (low_en && high_top_kib == high_len_kib + TOT_W'(LOW_KIB)));

    assert_small_no_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !high_en |-> (high_len_kib == '0 && high_top_kib == '0));

endmodule

// File: rtl/dram_bank_decoder.sv
module dram_bank_decoder
    import dram_map_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INST_W  = 19,
    parameter int TOT_W   = 21,
    parameter int LOW_KIB = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    input  logic [NBANK*INST_W-1:0] inst_kib,
    input  logic [NBANK-1:0]        inst_dbl,
    output logic                    map_valid,
    output logic                    low_en,
    output logic                    high_en,
    output logic [TOT_W-1:0]        high_len_kib,
    output logic [TOT_W-1:0]        high_top_kib,
    output logic [TOT_W-1:0]        total_kib
);

    logic [15:0]             cfg_word;
    logic [3:0]              bank_en;
    logic                    recalc_req;
    logic [NBANK*INST_W-1:0] eff_flat;

    dram_cfg_regs #(
        .ADDR_W   (ADDR_W),
        .CFG0_ADDR(8'h58),
        .CFG1_ADDR(8'h59),
        .EN_ADDR  (8'h5C)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .cfg_word  (cfg_word),
        .bank_en   (bank_en),
        .recalc_req(recalc_req)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            dram_bank_eval #(
                .INST_W (INST_W),
                .MIN_KIB(MIN_KIB)
            ) u_eval (
                .setting (cfg_word[b*NIB_W +: NIB_W]),
                .bank_on (bank_en[b]),
                .inst_kib(inst_kib[b*INST_W +: INST_W]),
                .inst_dbl(inst_dbl[b]),
                .eff_kib (eff_flat[b*INST_W +: INST_W])
            );
        end
    endgenerate

    dram_map_ctrl #(
        .INST_W (INST_W),
        .TOT_W  (TOT_W),
        .LOW_KIB(LOW_KIB)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .recalc_req  (recalc_req),
        .eff_flat    (eff_flat),
        .map_valid   (map_valid),
        .low_en      (low_en),
        .high_en     (high_en),
        .high_len_kib(high_len_kib),
        .high_top_kib(high_top_kib),
        .total_kib   (total_kib)
    );

endmodule

// File: tb/test_dram_bank_decoder.sv
`timescale 1ns/1ps
module test_dram_bank_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [75:0] inst_kib = '0;
    logic [3:0]  inst_dbl = '0;
    logic        map_valid, low_en, high_en;
    logic [20:0] high_len_kib, high_top_kib, total_kib;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dram_bank_decoder i_dram_bank_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .inst_kib(inst_kib), .inst_dbl(inst_dbl),
        .map_valid(map_valid), .low_en(low_en), .high_en(high_en),
        .high_len_kib(high_len_kib), .high_top_kib(high_top_kib), .total_kib(total_kib)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int  m_r58 = 0, m_r59 = 0, m_r5c = 0;
    int  m_pend = 0;
    bit  m_valid = 1, m_low = 0, m_high = 0;
    longint m_total = 0, m_len = 0, m_top = 0;

    function automatic longint model_sum();
        longint s = 0;
        for (int b = 0; b < 4; b++) begin
            int nib = ((b < 2 ? m_r58 : m_r59) >> (4 * (b % 2))) & 15;
            int code = (nib & 3) * 2 + ((nib >> 3) & 1);
            longint fit = inst_kib[b*19 +: 19];
            longint sz;
            if (((nib >> 3) & 1) == 1 && inst_dbl[b] == 1'b0) code = code - 1;
            sz = 2048 * (longint'(1) << code);
            if (fit < sz) sz = fit;
            if (((m_r5c >> b) & 1) == 0) sz = 0;
            s += sz;
        end
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_r58 = 0; m_r59 = 0; m_r5c = 0; m_pend = 0;
            m_valid = 1; m_low = 0; m_high = 0; m_total = 0; m_len = 0; m_top = 0;
        end else if (wr_en && (addr == 8'h58 || addr == 8'h59 || addr == 8'h5C)) begin
            if (addr == 8'h58) m_r58 = wdata;
            if (addr == 8'h59) m_r59 = wdata;
            if (addr == 8'h5C) m_r5c = wdata;
            m_pend = 2;
            m_valid = 0;
        end else if (m_pend > 0) begin
            m_pend--;
            if (m_pend == 0) begin
                m_total = model_sum();
                m_valid = 1;
                if (m_total > 1024) begin
                    m_low = 1; m_high = 1; m_len = m_total - 1024; m_top = m_total;
                end else begin
                    m_low = (m_total == 1024); m_high = 0; m_len = 0; m_top = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 map_valid per cycle", map_valid, m_valid);
            chk("R5 total per cycle", total_kib, m_total);
            chk("R6 low_en per cycle", low_en, m_low);
            chk("R6 high_en per cycle", high_en, m_high);
            chk("R7 high_len per cycle", high_len_kib, m_len);
            chk("R6 high_top per cycle", high_top_kib, m_top);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input int exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic fit(input int b, input int kib, input bit dbl);
        inst_kib[b*19 +: 19] = 19'(kib);
        inst_dbl[b] = dbl;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        fit(0, 16384, 0);
        fit(1, 16384, 1);
        fit(2, 1024, 0);
        fit(3, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 valid", map_valid, 1);
        chk("R10 total", total_kib, 0);
        chk("R10 low_en", low_en, 0);
        chk("R10 high_en", high_en, 0);
        rd("R10 reg58", 8'h58, 0);
        rd("R10 reg5C", 8'h5C, 0);

        // R1 R2 R5 R6: bank0 type2 single (32768, fitted 16384), bank1 type1 double (16384)
        wr(8'h58, 8'h92);
        wr(8'h5C, 8'h03);
        chk("R9 valid low after k", map_valid, 0);
        @(negedge clk);
        chk("R9 valid low after k+1", map_valid, 0);
        @(negedge clk);
        chk("R9 valid high after k+2", map_valid, 1);
        chk("R5 total two banks", total_kib, 32768);
        chk("R6 high_len", high_len_kib, 31744);
        chk("R6 high_top", high_top_kib, 32768);
        rd("R11 readback 58", 8'h58, 8'h92);

        // R4: bank0 double-sided setting with single-sided module -> 8192
        wr(8'h58, 8'h99);
        settle();
        chk("R4 corrected size", total_kib, 8192 + 16384);

        // R3: only bank1 enabled
        wr(8'h5C, 8'h02);
        settle();
        chk("R3 disabled bank zero", total_kib, 16384);

        // R7: only bank2 (fitted 1024) -> exactly 1 MiB
        wr(8'h59, 8'h00);
        wr(8'h5C, 8'h04);
        settle();
        chk("R7 exact total", total_kib, 1024);
        chk("R7 low only", low_en, 1);
        chk("R7 no high", high_en, 0);

        // R7: only bank3 (nothing fitted) -> both off
        wr(8'h5C, 8'h08);
        settle();
        chk("R7 below low", low_en, 0);
        chk("R7 below high", high_en, 0);

        // R8 R11: foreign address write ignored
        wr(8'h5D, 8'hFF);
        chk("R8 valid stays", map_valid, 1);
        rd("R11 other addr", 8'h5D, 0);
        rd("R8 reg5C unchanged", 8'h5C, 8'h08);

        // R9 restart: back-to-back writes
        wr(8'h5C, 8'h01);
        wr(8'h59, 8'h10);
        @(negedge clk);
        chk("R9 restart still low", map_valid, 0);
        @(negedge clk);
        chk("R9 restart done", map_valid, 1);
        rd("R11 readback 59", 8'h59, 8'h10);

        // R12: four 256 MiB double-sided banks
        for (int b = 0; b < 4; b++) fit(b, 262144, 1);
        wr(8'h58, 8'hBB);
        wr(8'h59, 8'hBB);
        wr(8'h5C, 8'h0F);
        settle();
        chk("R12 full total", total_kib, 1048576);
        chk("R12 high_len", high_len_kib, 1047552);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule